// File: doc/BRIEF.md
# Shared General-Purpose I/O Port

This block is a parameterised bank of general-purpose pins. Each pin has a direction bit, an output latch bit and a synchronised sample of the pad level. A small register bus reaches three addresses: the direction register, the latch register and the pin register. Writes to either the latch address or the pin address go into the output latch. Reads from the pin address return what is on the pads.

An on-chip peripheral can take a pin over, one pin at a time. The peripheral takes the pin when its enable and its output-enable for that pin are both high. The pad's data and output enable then come from the peripheral instead of the port. The pin can still be sampled through the pin address. A parameter mask names the pins that exist. Missing pins read as zero and are never driven.

The block has no sequencing of its own, so it has no state machine. Register selection is decoded through an enumerated select type. Its four values are direction, latch, pin and none. Register updates happen on the clock edge that samples the write strobe.

Top module: `gpio_share_port`

## Requirements
- R1: After reset, every implemented direction bit reads 1 (all pins are inputs), the latch reads 0 and `pad_oe` is 0.
- R2: A write to address 0 sets the direction register, where 1 means input and 0 means output. For a pin no peripheral owns, `pad_oe` is the inverse of its direction bit.
- R3: A write to address 1 updates the latch. A read of address 1 returns the latch contents and never the pad levels.
- R4: A write to address 2 updates the latch exactly as a write to address 1 does, and leaves the direction register unchanged.
- R5: A read of address 2 returns `pad_in` as sampled through two flip-flops. A pad change shows up on the second rising edge after it.
- R6: Bits that are zero in `IMPL_MASK` read 0 at addresses 0, 1 and 2. They also always drive 0 on `pad_out` and `pad_oe`.
- R7: When `periph_en` and `periph_oe` are both 1 on an implemented pin, `pad_oe` is 1 and `pad_out` equals `periph_dout` for that pin.
- R8: When `periph_en` is 1 but `periph_oe` is 0, the pin follows the port's direction and latch bits.
- R9: A pin owned by a peripheral still reads its pad level at address 2.
- R10: Address 3 reads as 0 and writes to it change nothing. Read data is 0 whenever `reg_rd` is low.
- R11: On a pin no peripheral owns, `pad_out` equals the latch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 direction, 1 latch, 2 pin, 3 none |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | WIDTH | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | WIDTH | Read data, combinational |
| periph_en | input | WIDTH | Per-pin peripheral enable |
| periph_dout | input | WIDTH | Per-pin peripheral output data |
| periph_oe | input | WIDTH | Per-pin peripheral output enable |
| pad_in | input | WIDTH | Pad input levels |
| pad_out | output | WIDTH | Pad output data |
| pad_oe | output | WIDTH | Pad output enable |

## Verification
The bench drives pads with values that differ from the latch. A design that returns pin levels at the latch address, or the latch at the pin address, fails the read checks.

Writes to the pin address are checked for landing in the latch and for leaving direction untouched. A decode that routes them to the direction register is caught.

The two-stage lag is checked edge by edge: the old value must still read after one edge, and the new value must read after two. A design with one sampling stage or three fails this check.

Random peripheral patterns mix three pin states: owned, enabled but not driving, and idle. These checks expose a mux keyed on the enable alone, or unmasked bits that still drive a pad.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;

    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_LAT  = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } gpio_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q  <= '0;
            sync_out <= '0;
        end else begin
            stage_q  <= async_in;
            sync_out <= stage_q;
        end
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_share_pkg::*;
#(
    parameter int               WIDTH     = 16,
    parameter logic [WIDTH-1:0] IMPL_MASK = 16'h7FF3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_sel_e        wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lat_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= IMPL_MASK;
            lat_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_DIR:          dir_q <= wr_data & IMPL_MASK;
                SEL_LAT, SEL_PIN: lat_q <= wr_data & IMPL_MASK;
                default:          ;
            endcase
        end
    end

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DIR) |=> dir_q == ($past(wr_data) & IMPL_MASK)); // R2

    AST_LAT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_LAT || wr_sel == SEL_PIN))
            |=> lat_q == ($past(wr_data) & IMPL_MASK)); // R3

    AST_PIN_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PIN) |=> $stable(dir_q)); // R4

    AST_NONE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_sel == SEL_NONE) |=> ($stable(dir_q) && $stable(lat_q))); // R10

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q | lat_q) & ~IMPL_MASK) == '0); // R6

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int               WIDTH     = 16,
    parameter logic [WIDTH-1:0] IMPL_MASK = 16'h7FF3
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] periph_en,
    input  logic [WIDTH-1:0] periph_dout,
    input  logic [WIDTH-1:0] periph_oe,
    output logic [WIDTH-1:0] owned,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (IMPL_MASK[i]) begin : g_impl
            always_comb begin
                owned[i] = periph_en[i] & periph_oe[i];
                if (owned[i]) begin
                    pad_out[i] = periph_dout[i];
                    pad_oe[i]  = 1'b1;
                end else begin
                    pad_out[i] = lat_q[i];
                    pad_oe[i]  = ~dir_q[i];
                end
            end
        end else begin : g_absent
            always_comb begin
                owned[i]   = 1'b0;
                pad_out[i] = 1'b0;
                pad_oe[i]  = 1'b0;
            end
        end
    end

endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
    import gpio_share_pkg::*;
#(
    parameter int               WIDTH     = 16,
    parameter logic [WIDTH-1:0] IMPL_MASK = 16'h7FF3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [WIDTH-1:0] reg_wdata,
    input  logic             reg_rd,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic [WIDTH-1:0] periph_en,
    input  logic [WIDTH-1:0] periph_dout,
    input  logic [WIDTH-1:0] periph_oe,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    gpio_sel_e        sel;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] pin_q;
    logic [WIDTH-1:0] owned;

    assign sel = gpio_sel_e'(reg_addr);

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_q)
    );

    gpio_regs #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (sel),
        .wr_data (reg_wdata),
        .dir_q   (dir_q),
        .lat_q   (lat_q)
    );

    gpio_pad_mux #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_mux (
        .dir_q       (dir_q),
        .lat_q       (lat_q),
        .periph_en   (periph_en),
        .periph_dout (periph_dout),
        .periph_oe   (periph_oe),
        .owned       (owned),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (sel)
                SEL_DIR:  reg_rdata = dir_q;
                SEL_LAT:  reg_rdata = lat_q;
                SEL_PIN:  reg_rdata = pin_q & IMPL_MASK;
                default:  reg_rdata = '0;
            endcase
        end
    end

    // Cycles since reset, saturating, so the lag check never reaches before reset.
    logic [1:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst_q <= '0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    AST_PIN_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3 && reg_rd && sel == SEL_PIN)
            |-> reg_rdata == ($past(pad_in, 2) & IMPL_MASK)); // R5

    AST_OE_NEEDS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~owned & dir_q) == '0); // R2

    AST_PERIPH_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        ((periph_en & periph_oe & IMPL_MASK) & ~pad_oe) == '0); // R7

    AST_NO_DRIVE_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_out) & ~IMPL_MASK) == '0); // R6

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> reg_rdata == '0); // R10

endmodule

// File: tb/gpio_share_port_bench.sv
`timescale 1ns/1ps
module gpio_share_port_bench;

    localparam int          W    = 16;
    localparam logic [15:0] MASK = 16'h7FF3;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   reg_addr;
    logic         reg_wr;
    logic [W-1:0] reg_wdata;
    logic         reg_rd;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] periph_en, periph_dout, periph_oe, pad_in;
    logic [W-1:0] pad_out, pad_oe;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [W-1:0] m_dir, m_lat;

    always #5 clk = ~clk;

    gpio_share_port u_gpio_share_port (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .periph_en(periph_en), .periph_dout(periph_dout), .periph_oe(periph_oe),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [W-1:0] exp_oe(logic [W-1:0] d, logic [W-1:0] pe, logic [W-1:0] po);
        logic [W-1:0] own = pe & po & MASK;
        return own | (~own & ~d & MASK);
    endfunction

    function automatic logic [W-1:0] exp_out(logic [W-1:0] l, logic [W-1:0] pe,
                                             logic [W-1:0] pd, logic [W-1:0] po);
        logic [W-1:0] own = pe & po & MASK;
        return ((own & pd) | (~own & l)) & MASK;
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(string tag, logic [1:0] a, logic [W-1:0] exp);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        chk(tag, reg_rdata, exp);
        reg_rd = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0) m_dir = d & MASK;
        else if (a == 2'd1 || a == 2'd2) m_lat = d & MASK;
    endtask

    task automatic settle(int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] a_val, b_val;
        void'($urandom(32'd4242));
        rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; reg_rd = 1'b0;
        periph_en = '0; periph_dout = '0; periph_oe = '0; pad_in = 16'hA5C3;
        m_dir = MASK; m_lat = '0;
        settle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 dir", 2'd0, MASK);
        rd_chk("R1 lat", 2'd1, '0);
        chk("R1 pad_oe", pad_oe, '0);

        // R10 idle read and address 3
        reg_addr = 2'd1; #1;
        chk("R10 rd low", reg_rdata, '0);
        wr(2'd3, 16'hFFFF);
        rd_chk("R10 addr3 read", 2'd3, '0);
        rd_chk("R10 dir kept", 2'd0, MASK);
        rd_chk("R10 lat kept", 2'd1, '0);

        // R2 / R11 / R6 direction and latch drive the pads
        wr(2'd0, 16'h00F0);
        wr(2'd1, 16'hFFFF);
        rd_chk("R2 dir read", 2'd0, 16'h00F0 & MASK);
        chk("R2 pad_oe", pad_oe, ~16'h00F0 & MASK);
        chk("R11 pad_out", pad_out, MASK);
        rd_chk("R6 lat masked", 2'd1, MASK);

        // R4 pin write lands in latch, direction unchanged
        wr(2'd2, 16'h1234);
        rd_chk("R4 lat", 2'd1, 16'h1234 & MASK);
        rd_chk("R4 dir", 2'd0, 16'h00F0 & MASK);

        // R3 latch read differs from pins
        pad_in = 16'h0F0F; settle(3);
        rd_chk("R3 lat not pins", 2'd1, 16'h1234 & MASK);
        rd_chk("R6 pin masked", 2'd2, 16'h0F0F & MASK);

        // R5 two-edge lag
        a_val = 16'h0F0F; b_val = 16'hF0F0;
        pad_in = b_val;
        @(posedge clk); @(negedge clk);
        rd_chk("R5 after one edge", 2'd2, a_val & MASK);
        @(posedge clk); @(negedge clk);
        rd_chk("R5 after two edges", 2'd2, b_val & MASK);

        // R7 / R8 / R9 peripheral ownership
        wr(2'd0, 16'hFFFF);
        periph_en = 16'hFFFF; periph_oe = 16'h000F; periph_dout = 16'h0005;
        pad_in = 16'h000C; #1;
        chk("R7 pad_oe", pad_oe, 16'h000F & MASK);
        chk("R7 pad_out", pad_out, (16'h0005 & 16'h000F & MASK) | (~16'h000F & m_lat));
        chk("R8 not driving", pad_oe & 16'hFFF0, 16'h0000);
        settle(2);
        rd_chk("R9 owned pin read", 2'd2, 16'h000C & MASK);
        periph_en = '0; periph_oe = '0; #1;

        // Random mix, against bench model
        for (int it = 0; it < 300; it++) begin
            logic [1:0]   a = 2'($urandom_range(0, 3));
            logic [W-1:0] d = W'($urandom);
            periph_en   = W'($urandom);
            periph_oe   = W'($urandom);
            periph_dout = W'($urandom);
            pad_in      = W'($urandom);
            wr(a, d);
            settle(2);
            rd_chk("R2 rand dir", 2'd0, m_dir);
            rd_chk("R3 rand lat", 2'd1, m_lat);
            rd_chk("R5 rand pin", 2'd2, pad_in & MASK);
            chk("R7 rand oe", pad_oe, exp_oe(m_dir, periph_en, periph_oe));
            chk("R11 rand out", pad_out, exp_out(m_lat, periph_en, periph_dout, periph_oe));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule